// File: doc/BRIEF.md
# Banked General-Purpose Register File

This block holds the integer working registers of a processor core: two combinational read ports and one write port, every entry 32 bits wide. A parameter chooses a full build with 32 architectural registers or a reduced build with 16. Another parameter replicates the whole set into several shadow banks. A 4-bit context identifier from outside chooses the bank used for every access. If the identifier is larger than the number of banks built, it wraps modulo the bank count.

Register 0 always reads as zero, and a write to it is discarded. In the reduced build a register number from 16 to 31 is outside the file. Naming one on a read port, or on an enabled write, raises a one-cycle range-exception strobe on the next cycle. Such a read returns zero, and such a write changes nothing. Storage is not cleared by reset. Reset only clears the exception strobe and blocks writes while it is held. Software emulation of the missing registers and operand forwarding are left to the surrounding pipeline.

Top module: `gpr_bank_file`

## Requirements
- R1: A read port returns the value most recently written to the addressed register (1 to NUM_REGS-1) of the selected bank, and the two read ports work independently.
- R2: Register 0 reads as zero on both ports in every bank, and a write to register 0 has no effect.
- R3: A write takes effect at the rising clock edge. A read of the register being written in the same cycle returns the previous value, and the new value appears from the next cycle on.
- R4: The bank used is ctx_id modulo NUM_BANKS. Banks are independent, so a write in one bank is not visible in another.
- R5: In a 16-register build, a read address of 16 or more on either port, or an enabled write to address 16 or more, drives range_exc high for exactly the following cycle. An out-of-range read returns zero.
- R6: An enabled write that raises the range exception modifies no register; for example, a write to 19 leaves register 3 unchanged.
- R7: In a 32-register build range_exc never rises, and registers 16 to 31 store and return data like the others.
- R8: range_exc is low in the cycle after any cycle with rst_n low, whatever the address inputs were. A write presented while rst_n is low changes no register.
- R9: With wr_en low, wr_addr and wr_data have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the exception strobe update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the strobe and blocks writes |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_addr_b | input | 5 | Register number for read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Value to write |
| ctx_id | input | 4 | Context identifier that selects the shadow bank |
| rd_data_a | output | 32 | Read port A value (combinational) |
| rd_data_b | output | 32 | Read port B value (combinational) |
| range_exc | output | 1 | One-cycle strobe that follows an out-of-range reference |

## Verification
A write and a read of the same register in the same cycle is the main collision. The bench drives both ports at the address being written and expects the old value that cycle and the new value one cycle later. A second collision is an out-of-range write alongside in-range reads. There the bench expects the strobe on the next cycle and an unchanged aliased low register. One bench drives the same stimulus into a 16-register, 3-bank build and a 32-register, 2-bank build. It keeps an arithmetic model of each and sweeps every context value against every register address on both ports.

// File: rtl/gprf_pkg.sv
// Shared types and constants for the banked register file.
// Assumes 32-bit entries, 5-bit register numbers and a 4-bit context id.
package gprf_pkg;
    localparam int GPR_W  = 32;
    localparam int ADDR_W = 5;
    localparam int CTX_W  = 4;

    typedef logic [GPR_W-1:0]  word_t;
    typedef logic [ADDR_W-1:0] gpr_addr_t;
    typedef logic [CTX_W-1:0]  ctx_t;

    // True when a bank count is a power of two (1 counts as one).
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction
endpackage

// File: rtl/gprf_range_check.sv
// Compares each referenced register number with the built register count.
// Assumes NUM_REGS is 16 or 32; in a 32 build every reference is legal.
module gprf_range_check
    import gprf_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  gpr_addr_t rd_addr_a,
    input  gpr_addr_t rd_addr_b,
    input  gpr_addr_t wr_addr,
    input  logic      wr_en,
    output logic      rd_a_ok,
    output logic      rd_b_ok,
    output logic      wr_ok,
    output logic      violation
);
    localparam int CMP_W = ADDR_W + 1;
    localparam logic [CMP_W-1:0] LIMIT = CMP_W'(NUM_REGS);

    // Legality of each address against the register count.
    always_comb begin
        rd_a_ok = ({1'b0, rd_addr_a} < LIMIT);
        rd_b_ok = ({1'b0, rd_addr_b} < LIMIT);
        wr_ok   = ({1'b0, wr_addr}   < LIMIT);
    end

    // Any illegal read, or an illegal write that is enabled, is a violation.
    always_comb begin
        violation = !rd_a_ok || !rd_b_ok || (wr_en && !wr_ok);
    end
endmodule

// File: rtl/gprf_bank_sel.sv
// Maps the 4-bit context id onto an implemented bank, wrapping modulo NUM_BANKS.
// Assumes 1 <= NUM_BANKS <= 16; a power-of-two count uses a mask, others a remainder.
module gprf_bank_sel
    import gprf_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  ctx_t              ctx_id,
    output logic [BANK_W-1:0] bank_idx
);
    generate
        if (is_pow2(NUM_BANKS)) begin : g_mask
            // Power-of-two bank count: keep the low context bits.
            always_comb begin
                bank_idx = BANK_W'(ctx_id & CTX_W'(NUM_BANKS - 1));
            end
        end else begin : g_mod
            // Other bank counts: true remainder of the context id.
            always_comb begin
                bank_idx = BANK_W'(ctx_id % CTX_W'(NUM_BANKS));
            end
        end
    endgenerate

    // The chosen bank always exists (R4).
    always_comb begin
        assert_bank_exists_R4: assert (int'(bank_idx) < NUM_BANKS);
    end
endmodule

// File: rtl/gprf_bank.sv
// One shadow set of registers: two asynchronous reads and one clocked write.
// Assumes the caller filters register 0, range errors and reset from wr_en.
// Storage has no reset by design.
module gprf_bank
    import gprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output word_t            rd_data_a,
    output word_t            rd_data_b
);
    word_t regs [NUM_REGS];

    // Store the write data on the rising edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Present both read values combinationally.
    always_comb begin
        rd_data_a = regs[rd_idx_a];
        rd_data_b = regs[rd_idx_b];
    end
endmodule

// File: rtl/gpr_bank_file.sv
// Banked two-read, one-write general-purpose register file.
// Assumes NUM_REGS is 16 or 32 and NUM_BANKS is 1..16. The bank is picked
// by ctx_id modulo NUM_BANKS. Reads are combinational; writes land on the clock edge.
// range_exc is a registered strobe one cycle after an out-of-range reference.
module gpr_bank_file
    import gprf_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int NUM_BANKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  rd_addr_a,
    input  logic [4:0]  rd_addr_b,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  ctx_id,
    output logic [31:0] rd_data_a,
    output logic [31:0] rd_data_b,
    output logic        range_exc
);
    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic              rd_a_ok, rd_b_ok, wr_ok, violation;
    logic [BANK_W-1:0] bank_idx;
    logic              wr_fire;
    logic [NUM_BANKS-1:0] bank_we;
    word_t             bank_rd_a [NUM_BANKS];
    word_t             bank_rd_b [NUM_BANKS];
    logic [IDX_W-1:0]  wr_idx, rd_idx_a, rd_idx_b;

    gprf_range_check #(.NUM_REGS(NUM_REGS)) u_range (
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .wr_addr   (wr_addr),
        .wr_en     (wr_en),
        .rd_a_ok   (rd_a_ok),
        .rd_b_ok   (rd_b_ok),
        .wr_ok     (wr_ok),
        .violation (violation)
    );

    gprf_bank_sel #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_sel (
        .ctx_id   (ctx_id),
        .bank_idx (bank_idx)
    );

    // Register indices within a bank.
    always_comb begin
        wr_idx   = wr_addr[IDX_W-1:0];
        rd_idx_a = rd_addr_a[IDX_W-1:0];
        rd_idx_b = rd_addr_b[IDX_W-1:0];
    end

    // A write commits only out of reset, in range and away from register 0.
    always_comb begin
        wr_fire = rst_n && wr_en && wr_ok && (wr_addr != '0);
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_we[b] = wr_fire && (bank_idx == BANK_W'(b));
            gprf_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
                .clk       (clk),
                .wr_en     (bank_we[b]),
                .wr_idx    (wr_idx),
                .wr_data   (wr_data),
                .rd_idx_a  (rd_idx_a),
                .rd_idx_b  (rd_idx_b),
                .rd_data_a (bank_rd_a[b]),
                .rd_data_b (bank_rd_b[b])
            );
        end
    endgenerate

    // Select the active bank and force zero for register 0 or out-of-range reads.
    always_comb begin
        rd_data_a = (rd_a_ok && rd_addr_a != '0) ? bank_rd_a[bank_idx] : '0;
        rd_data_b = (rd_b_ok && rd_addr_b != '0) ? bank_rd_b[bank_idx] : '0;
    end

    // Register the exception strobe; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_exc <= 1'b0;
        end else begin
            range_exc <= violation;
        end
    end

    // R1: a committed write is returned on the next cycle from the same bank.
    assert_read_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_fire) && ($past(wr_addr) == rd_addr_a) && ($past(bank_idx) == bank_idx))
        |-> (rd_data_a == $past(wr_data)));

    // R2: register 0 reads as zero.
    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr_a == '0) |-> (rd_data_a == '0)));

    // R5: a violation is followed by the strobe.
    assert_exc_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> range_exc);

    // R5: the strobe only follows a violation.
    assert_exc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc |-> $past(violation));

    // R6: an out-of-range write enables no bank.
    assert_no_write_on_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |-> (bank_we == '0));

    // R4: at most one bank takes a write.
    assert_single_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    generate
        if (NUM_REGS == 32) begin : g_full_chk
            // R7: a full build never raises the strobe.
            assert_full_no_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !range_exc);
        end
    endgenerate
endmodule

// File: tb/gpr_bank_file_tb.sv
// Drives one stimulus stream into a 16-register/3-bank build and a
// 32-register/2-bank build and compares both with arithmetic models.
module gpr_bank_file_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra = '0, rb = '0, wa = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [3:0]  ctx = '0;
    logic [31:0] rd_a_s, rd_b_s, rd_a_f, rd_b_f;
    logic        exc_s, exc_f;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_s [3][16];
    bit          kn_s  [3][16];
    logic [31:0] exp_f [2][32];
    bit          kn_f  [2][32];
    bit          pend_s = 1'b0;
    bit          prev_rst = 1'b1;

    always #4 clk = ~clk;

    gpr_bank_file #(.NUM_REGS(16), .NUM_BANKS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_addr_a(ra), .rd_addr_b(rb),
        .wr_en(we), .wr_addr(wa), .wr_data(wd), .ctx_id(ctx),
        .rd_data_a(rd_a_s), .rd_data_b(rd_b_s), .range_exc(exc_s)
    );

    gpr_bank_file #(.NUM_REGS(32), .NUM_BANKS(2)) u_dut_full (
        .clk(clk), .rst_n(rst_n), .rd_addr_a(ra), .rd_addr_b(rb),
        .wr_en(we), .wr_addr(wa), .wr_data(wd), .ctx_id(ctx),
        .rd_data_a(rd_a_f), .rd_data_b(rd_b_f), .range_exc(exc_f)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Check a read of the 16-register build against its model.
    task automatic rd_s(logic [4:0] a, logic [31:0] act, int c, string tag, string what);
        int bk = c % 3;
        if (a == 0) chk("R2", what, act, 32'h0);
        else if (a >= 16) chk("R5", what, act, 32'h0);
        else if (kn_s[bk][a[3:0]]) chk(tag, what, act, exp_s[bk][a[3:0]]);
    endtask

    // Check a read of the 32-register build against its model.
    task automatic rd_f(logic [4:0] a, logic [31:0] act, int c, string tag, string what);
        int bk = c % 2;
        if (a == 0) chk("R2", what, act, 32'h0);
        else if (kn_f[bk][a] && a >= 16) chk("R7", what, act, exp_f[bk][a]);
        else if (kn_f[bk][a]) chk(tag, what, act, exp_f[bk][a]);
    endtask

    // One cycle: check last cycle's strobe, apply inputs, check reads, update models.
    task automatic step(logic [4:0] a, logic [4:0] b, logic [4:0] w, logic [31:0] d,
                        logic e, logic [3:0] c, logic r, string tag);
        @(negedge clk);
        chk(prev_rst ? "R8" : "R5", "small range_exc", {31'h0, exc_s}, {31'h0, pend_s});
        chk("R7", "full range_exc", {31'h0, exc_f}, 32'h0);
        ra = a; rb = b; wa = w; wd = d; we = e; ctx = c; rst_n = r;
        #1;
        rd_s(a, rd_a_s, int'(c), tag, "small port A");
        rd_s(b, rd_b_s, int'(c), tag, "small port B");
        rd_f(a, rd_a_f, int'(c), tag, "full port A");
        rd_f(b, rd_b_f, int'(c), tag, "full port B");
        pend_s = r && ((a >= 16) || (b >= 16) || (e && w >= 16));
        prev_rst = !r;
        if (r && e && w != 0 && w < 16) begin
            exp_s[int'(c) % 3][w[3:0]] = d;
            kn_s[int'(c) % 3][w[3:0]] = 1'b1;
        end
        if (r && e && w != 0) begin
            exp_f[int'(c) % 2][w] = d;
            kn_f[int'(c) % 2][w] = 1'b1;
        end
    endtask

    initial begin
        // R8: out-of-range reads and writes under reset leave the strobe low.
        repeat (3) step(5'd20, 5'd0, 5'd7, 32'h7777_7777, 1'b1, 4'd0, 1'b0, "R8");
        step(5'd0, 5'd0, 5'd0, 32'h0, 1'b0, 4'd0, 1'b1, "R8");

        // R1: fill every register of each bank; register 0 and 16..31 writes included.
        for (int c = 0; c < 3; c++) begin
            for (int r = 0; r < 32; r++) begin
                step(5'(r), 5'(31 - r), 5'(r), 32'hC0DE_0000 ^ (32'(c) << 12) ^ (32'(r) * 32'h0001_0101),
                     1'b1, 4'(c), 1'b1, "R1");
            end
        end

        // R4: sweep every context against every address on both ports.
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 32; a++) begin
                step(5'(a), 5'(31 - a), 5'd0, 32'h0, 1'b0, 4'(c), 1'b1, "R4");
            end
        end

        // R3: same-cycle write and read return the old value, then the new one.
        step(5'd5, 5'd5, 5'd5, 32'h3333_0005, 1'b1, 4'd1, 1'b1, "R3");
        step(5'd5, 5'd5, 5'd0, 32'h0, 1'b0, 4'd1, 1'b1, "R3");

        // R9: data on the write port with enable low is ignored.
        step(5'd6, 5'd0, 5'd6, 32'hDEAD_BEEF, 1'b0, 4'd2, 1'b1, "R9");
        step(5'd6, 5'd6, 5'd0, 32'h0, 1'b0, 4'd2, 1'b1, "R9");

        // R6: a write to 19 raises the strobe and leaves register 3 intact.
        step(5'd3, 5'd0, 5'd19, 32'h1234_5678, 1'b1, 4'd0, 1'b1, "R6");
        step(5'd3, 5'd19, 5'd0, 32'h0, 1'b0, 4'd0, 1'b1, "R6");
        step(5'd3, 5'd3, 5'd0, 32'h0, 1'b0, 4'd0, 1'b1, "R6");

        // R2: a write to register 0 is discarded.
        step(5'd0, 5'd0, 5'd0, 32'hFFFF_FFFF, 1'b1, 4'd1, 1'b1, "R2");
        step(5'd0, 5'd0, 5'd0, 32'h0, 1'b0, 4'd1, 1'b1, "R2");

        // R8: a write under a second reset changes nothing.
        step(5'd9, 5'd0, 5'd9, 32'hBAD0_0009, 1'b1, 4'd1, 1'b0, "R8");
        step(5'd9, 5'd9, 5'd0, 32'h0, 1'b0, 4'd1, 1'b1, "R8");

        // R4: the same register in different banks holds different values.
        step(5'd0, 5'd0, 5'd12, 32'h0A0A_0A0A, 1'b1, 4'd0, 1'b1, "R4");
        step(5'd0, 5'd0, 5'd12, 32'h0B0B_0B0B, 1'b1, 4'd1, 1'b1, "R4");
        step(5'd12, 5'd12, 5'd0, 32'h0, 1'b0, 4'd0, 1'b1, "R4");
        step(5'd12, 5'd12, 5'd0, 32'h0, 1'b0, 4'd1, 1'b1, "R4");
        step(5'd12, 5'd12, 5'd0, 32'h0, 1'b0, 4'd3, 1'b1, "R4");
        step(5'd12, 5'd12, 5'd0, 32'h0, 1'b0, 4'd15, 1'b1, "R4");
        step(5'd0, 5'd0, 5'd0, 32'h0, 1'b0, 4'd0, 1'b1, "R5");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule